// File: doc/BRIEF.md
# Core Launch and Debug-Break Sequencer

This unit sits beside one processor core and controls how that core is started and how it is stopped for debugging. A launch request carries an operand word whose bit 5 picks one of two start modes. In copy mode the unit reads a fixed number of words from shared memory, starting at a given byte address, and writes them into the core's local register file. It then tells the core to jump to local address 0. In direct mode it copies nothing and tells the core to jump straight to a supplied program address.

The core never runs its first program instruction unguarded. The cycle after the jump is issued, the unit requests a fetch from this core's debug vector in shared memory. The vector address is a fixed base plus four bytes for each core number. The handler code at that vector can set up single-step for any of four execution contexts and can arm an address breakpoint. If the vector holds nothing but a return, all break sources stay cleared and the core runs at full speed. Another core can still force a break by raising the asynchronous request.

While a handler runs, every break source is masked. The unit arms again only when the handler's return is reported. When several sources hit in the same cycle, exactly one debug entry is taken, and its cause is reported.

Top module: `core_launch_dbg`

## Requirements
- R1: With launch_op bit 5 = 0, the unit reads LOAD_WORDS words. Word i is read from launch_addr + 4*i (rd_req high, one word per cycle in which rd_gnt is high). In the same cycle it is written to register i (rf_we, rf_waddr = i, rf_wdata = rd_data). After the last word it issues a jump to address 0.
- R2: With launch_op bit 5 = 1, rd_req stays low, and start_pc_valid pulses with start_pc = launch_pc in the cycle after the request.
- R3: busy goes high the cycle after an accepted launch. It stays high through the cycle in which start_pc_valid is high, and is low otherwise; everything is idle after reset.
- R4: In the cycle after start_pc_valid, vec_req pulses for one cycle with brk_cause = 0 (initial break). dbg_active is high from that cycle until dbg_ret is seen.
- R5: vec_addr equals 0x400 + 4*core_id, for every core_id from 0 to 15.
- R6: cfg_step_mask bit k enables single-step for context k (0 = main code, 1 to 3 = interrupt levels 1 to 3). When run is high and an instruction issues with an enabled issue_ctx, the next cycle gives vec_req with brk_cause = 3.
- R7: When run is high, the breakpoint is enabled, and an instruction issues with issue_pc equal to the breakpoint address, the next cycle gives vec_req with brk_cause = 2.
- R8: When run is high and async_req is high, the next cycle gives vec_req with brk_cause = 1, whether or not an instruction issues.
- R9: Sources that hit together give a single entry. The asynchronous request wins over the breakpoint, and the breakpoint wins over single-step.
- R10: While dbg_active is high, no break source causes vec_req. dbg_ret moves the unit to run in the next cycle.
- R11: Break settings are cleared at every launch and are written by cfg_we only while the handler is running (dbg_active high and vec_req low); a cfg_we at any other time is ignored. A handler that returns at once therefore leaves the core running with no breaks.
- R12: launch_req is ignored unless the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch_req | input | 1 | Launch request pulse |
| launch_op | input | 8 | Launch operand; bit 5 selects direct mode |
| launch_addr | input | 20 | Shared-memory byte address of the copy block |
| launch_pc | input | 20 | Start address for direct mode |
| core_id | input | 4 | This core's number |
| rd_req | output | 1 | Shared-memory read request during copy |
| rd_addr | output | 20 | Byte address of the word being read |
| rd_gnt | input | 1 | Read granted; rd_data valid this cycle |
| rd_data | input | 32 | Read data |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 9 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| busy | output | 1 | Launch in progress |
| start_pc_valid | output | 1 | Jump issue pulse |
| start_pc | output | 20 | Jump target |
| issue_valid | input | 1 | Core issues an instruction this cycle |
| issue_pc | input | 20 | Address of the issuing instruction |
| issue_ctx | input | 2 | Context of the issuing instruction |
| async_req | input | 1 | Break request from another core |
| cfg_we | input | 1 | Write break settings |
| cfg_step_mask | input | 4 | Per-context single-step enables |
| cfg_bkpt_en | input | 1 | Breakpoint enable |
| cfg_bkpt_addr | input | 20 | Breakpoint address |
| dbg_ret | input | 1 | Handler executed its return |
| vec_req | output | 1 | Debug vector fetch pulse |
| vec_addr | output | 20 | Debug vector byte address |
| brk_cause | output | 2 | 0 initial, 1 async, 2 breakpoint, 3 step |
| dbg_active | output | 1 | Debug handler entered or running |
| run | output | 1 | User program running with breaks armed |

## Verification
The assertions check on every cycle that a jump issue is followed at once by an initial-cause vector request, and that busy only falls after a jump. They also check that no vector request follows a handler cycle, that an async request during run always produces an async-cause entry, that copy writes step through consecutive indices, and that break settings never change outside the handler. Only the bench's scenarios show the actual copy addresses and data under gaps in the grant, the vector address for each core number, and the priority when sources coincide. The same holds for a configuration write or a launch request outside its window having no effect: this shows up only in later break behaviour.

// File: rtl/core_dbg_pkg.sv
package core_dbg_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_LOAD    = 3'd1,
      ST_JUMP    = 3'd2,
      ST_ENTER   = 3'd3,
      ST_HANDLER = 3'd4,
      ST_RUN     = 3'd5
   } seq_state_t;

   typedef enum logic [1:0] {
      BRK_INIT  = 2'd0,
      BRK_ASYNC = 2'd1,
      BRK_BKPT  = 2'd2,
      BRK_STEP  = 2'd3
   } brk_cause_t;
endpackage

// File: rtl/cls_word_loader.sv
module cls_word_loader #(
   parameter int MEM_AW     = 20,
   parameter int DATA_W     = 32,
   parameter int LOAD_WORDS = 512,
   localparam int IDX_W     = $clog2(LOAD_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [MEM_AW-1:0] base_addr,
   input  logic              active,
   input  logic              rd_gnt,
   input  logic [DATA_W-1:0] rd_data,
   output logic              rd_req,
   output logic [MEM_AW-1:0] rd_addr,
   output logic              rf_we,
   output logic [IDX_W-1:0]  rf_waddr,
   output logic [DATA_W-1:0] rf_wdata,
   output logic              done
);
   localparam int ADDR_SH = $clog2(DATA_W / 8);

   generate
      if (LOAD_WORDS < 2) begin : g_bad_words
         $error("LOAD_WORDS must be at least 2");
      end
      if ((DATA_W % 8) != 0) begin : g_bad_width
         $error("DATA_W must be a whole number of bytes");
      end
   endgenerate

   logic [IDX_W-1:0]  idx_q;
   logic [MEM_AW-1:0] base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         base_q <= '0;
      end else if (start) begin
         idx_q  <= '0;
         base_q <= base_addr;
      end else if (active && rd_gnt) begin
         idx_q  <= idx_q + 1'b1;
      end
   end

   assign rd_req   = active;
   assign rd_addr  = base_q + (MEM_AW'(idx_q) << ADDR_SH);
   assign rf_we    = active && rd_gnt;
   assign rf_waddr = idx_q;
   assign rf_wdata = rd_data;
   assign done     = rf_we && (idx_q == IDX_W'(LOAD_WORDS - 1));

   // R1: back-to-back writes land on consecutive register indices
   a_r1_seq_index: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && $past(rf_we)) |-> (rf_waddr == IDX_W'($past(rf_waddr) + 1'b1)));
endmodule

// File: rtl/cls_break_arbiter.sv
module cls_break_arbiter
   import core_dbg_pkg::*;
#(
   parameter int PC_W  = 20,
   parameter int N_CTX = 4,
   localparam int CTX_W = $clog2(N_CTX)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             cfg_accept,
   input  logic             cfg_we,
   input  logic [N_CTX-1:0] cfg_step_mask,
   input  logic             cfg_bkpt_en,
   input  logic [PC_W-1:0]  cfg_bkpt_addr,
   input  logic             armed,
   input  logic             issue_valid,
   input  logic [PC_W-1:0]  issue_pc,
   input  logic [CTX_W-1:0] issue_ctx,
   input  logic             async_req,
   output logic             take,
   output brk_cause_t       cause
);
   generate
      if (N_CTX < 2 || (N_CTX & (N_CTX - 1)) != 0) begin : g_bad_ctx
         $error("N_CTX must be a power of two of at least 2");
      end
   endgenerate

   logic [N_CTX-1:0] step_q;
   logic             bken_q;
   logic [PC_W-1:0]  bkaddr_q;
   logic [N_CTX-1:0] step_hit_v;
   logic             bk_hit;
   logic             step_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q   <= '0;
         bken_q   <= 1'b0;
         bkaddr_q <= '0;
      end else if (clr) begin
         step_q   <= '0;
         bken_q   <= 1'b0;
         bkaddr_q <= '0;
      end else if (cfg_accept && cfg_we) begin
         step_q   <= cfg_step_mask;
         bken_q   <= cfg_bkpt_en;
         bkaddr_q <= cfg_bkpt_addr;
      end
   end

   for (genvar k = 0; k < N_CTX; k++) begin : g_ctx
      assign step_hit_v[k] = issue_valid && step_q[k] && (issue_ctx == CTX_W'(k));
   end

   assign step_hit = |step_hit_v;
   assign bk_hit   = issue_valid && bken_q && (issue_pc == bkaddr_q);
   assign take     = armed && (async_req || bk_hit || step_hit);

   always_comb begin
      if (async_req)   cause = BRK_ASYNC;
      else if (bk_hit) cause = BRK_BKPT;
      else             cause = BRK_STEP;
   end

   // R11: settings only change in the handler window or at launch
   a_r11_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_accept && !clr) |=> ($stable(step_q) && $stable(bken_q) && $stable(bkaddr_q)));
endmodule

// File: rtl/cls_vector_calc.sv
module cls_vector_calc #(
   parameter int          MEM_AW     = 20,
   parameter int          ID_W       = 4,
   parameter logic [31:0] VEC_BASE   = 32'h400,
   parameter int          VEC_STRIDE = 4
) (
   input  logic [ID_W-1:0]   core_id,
   output logic [MEM_AW-1:0] vec_addr
);
   localparam int STRIDE_SH = $clog2(VEC_STRIDE);

   generate
      if (VEC_STRIDE < 1) begin : g_bad_stride
         $error("VEC_STRIDE must be positive");
      end
      if ((VEC_STRIDE & (VEC_STRIDE - 1)) == 0) begin : g_shift
         assign vec_addr = MEM_AW'(VEC_BASE) + (MEM_AW'(core_id) << STRIDE_SH);
      end else begin : g_mult
         assign vec_addr = MEM_AW'(VEC_BASE) + MEM_AW'(core_id) * MEM_AW'(VEC_STRIDE);
      end
   endgenerate
endmodule

// File: rtl/core_launch_dbg.sv
module core_launch_dbg
   import core_dbg_pkg::*;
#(
   parameter int          CFG_W      = 8,
   parameter int          MODE_BIT   = 5,
   parameter int          MEM_AW     = 20,
   parameter int          PC_W       = 20,
   parameter int          DATA_W     = 32,
   parameter int          LOAD_WORDS = 512,
   parameter int          ID_W       = 4,
   parameter int          N_CTX      = 4,
   parameter logic [31:0] VEC_BASE   = 32'h400,
   parameter int          VEC_STRIDE = 4,
   localparam int         IDX_W      = $clog2(LOAD_WORDS),
   localparam int         CTX_W      = $clog2(N_CTX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch_req,
   input  logic [CFG_W-1:0]  launch_op,
   input  logic [MEM_AW-1:0] launch_addr,
   input  logic [PC_W-1:0]   launch_pc,
   input  logic [ID_W-1:0]   core_id,
   output logic              rd_req,
   output logic [MEM_AW-1:0] rd_addr,
   input  logic              rd_gnt,
   input  logic [DATA_W-1:0] rd_data,
   output logic              rf_we,
   output logic [IDX_W-1:0]  rf_waddr,
   output logic [DATA_W-1:0] rf_wdata,
   output logic              busy,
   output logic              start_pc_valid,
   output logic [PC_W-1:0]   start_pc,
   input  logic              issue_valid,
   input  logic [PC_W-1:0]   issue_pc,
   input  logic [CTX_W-1:0]  issue_ctx,
   input  logic              async_req,
   input  logic              cfg_we,
   input  logic [N_CTX-1:0]  cfg_step_mask,
   input  logic              cfg_bkpt_en,
   input  logic [PC_W-1:0]   cfg_bkpt_addr,
   input  logic              dbg_ret,
   output logic              vec_req,
   output logic [MEM_AW-1:0] vec_addr,
   output logic [1:0]        brk_cause,
   output logic              dbg_active,
   output logic              run
);
   generate
      if (MODE_BIT >= CFG_W) begin : g_bad_mode
         $error("MODE_BIT must lie inside the launch operand");
      end
   endgenerate

   seq_state_t state_q, state_d;
   brk_cause_t cause_q;
   brk_cause_t arb_cause;
   logic [PC_W-1:0] target_q;
   logic launch_ok, direct_mode, load_done, brk_take;

   assign launch_ok   = (state_q == ST_IDLE) && launch_req;
   assign direct_mode = launch_op[MODE_BIT];

   cls_word_loader #(
      .MEM_AW(MEM_AW), .DATA_W(DATA_W), .LOAD_WORDS(LOAD_WORDS)
   ) u_loader (
      .clk(clk), .rst_n(rst_n),
      .start(launch_ok && !direct_mode), .base_addr(launch_addr),
      .active(state_q == ST_LOAD), .rd_gnt(rd_gnt), .rd_data(rd_data),
      .rd_req(rd_req), .rd_addr(rd_addr), .rf_we(rf_we),
      .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .done(load_done)
   );

   cls_break_arbiter #(.PC_W(PC_W), .N_CTX(N_CTX)) u_arbiter (
      .clk(clk), .rst_n(rst_n), .clr(launch_ok),
      .cfg_accept(state_q == ST_HANDLER), .cfg_we(cfg_we),
      .cfg_step_mask(cfg_step_mask), .cfg_bkpt_en(cfg_bkpt_en),
      .cfg_bkpt_addr(cfg_bkpt_addr), .armed(state_q == ST_RUN),
      .issue_valid(issue_valid), .issue_pc(issue_pc), .issue_ctx(issue_ctx),
      .async_req(async_req), .take(brk_take), .cause(arb_cause)
   );

   cls_vector_calc #(
      .MEM_AW(MEM_AW), .ID_W(ID_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
   ) u_vector (
      .core_id(core_id), .vec_addr(vec_addr)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (launch_req) state_d = direct_mode ? ST_JUMP : ST_LOAD;
         ST_LOAD:    if (load_done) state_d = ST_JUMP;
         ST_JUMP:    state_d = ST_ENTER;
         ST_ENTER:   state_d = ST_HANDLER;
         ST_HANDLER: if (dbg_ret) state_d = ST_RUN;
         ST_RUN:     if (brk_take) state_d = ST_ENTER;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cause_q  <= BRK_INIT;
         target_q <= '0;
      end else begin
         state_q <= state_d;
         if (launch_ok) target_q <= direct_mode ? launch_pc : '0;
         if (state_q == ST_JUMP) cause_q <= BRK_INIT;
         else if (state_q == ST_RUN && brk_take) cause_q <= arb_cause;
      end
   end

   assign busy           = (state_q == ST_LOAD) || (state_q == ST_JUMP);
   assign start_pc_valid = (state_q == ST_JUMP);
   assign start_pc       = target_q;
   assign vec_req        = (state_q == ST_ENTER);
   assign dbg_active     = (state_q == ST_ENTER) || (state_q == ST_HANDLER);
   assign run            = (state_q == ST_RUN);
   assign brk_cause      = cause_q;

   // R4: the jump is always followed by the initial break
   a_r4_initial_break: assert property (@(posedge clk) disable iff (!rst_n)
      start_pc_valid |=> (vec_req && brk_cause == 2'd0));
   // R3: busy only ends right after a jump issue
   a_r3_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(start_pc_valid));
   // R10: no debug entry directly after a handler cycle
   a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_active |=> !vec_req);
   // R8 / R9: an async request while running wins the entry
   a_r9_async_first: assert property (@(posedge clk) disable iff (!rst_n)
      (run && async_req) |=> (vec_req && brk_cause == 2'd1));
   // R5: vector address tracks the core number
   a_r5_vec_addr: assert property (@(posedge clk) disable iff (!rst_n)
      vec_req |-> (vec_addr == MEM_AW'(VEC_BASE) + MEM_AW'(core_id) * MEM_AW'(VEC_STRIDE)));
endmodule

// File: tb/core_launch_dbg_bench.sv
module core_launch_dbg_bench;
   localparam int NW = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic launch_req = 0; logic [7:0] launch_op = 0;
   logic [19:0] launch_addr = 0, launch_pc = 0;
   logic [3:0] core_id = 0;
   logic rd_req; logic [19:0] rd_addr; logic rd_gnt = 0; logic [31:0] rd_data = 0;
   logic rf_we; logic [2:0] rf_waddr; logic [31:0] rf_wdata;
   logic busy, start_pc_valid; logic [19:0] start_pc;
   logic issue_valid = 0; logic [19:0] issue_pc = 0; logic [1:0] issue_ctx = 0;
   logic async_req = 0, cfg_we = 0; logic [3:0] cfg_step_mask = 0;
   logic cfg_bkpt_en = 0; logic [19:0] cfg_bkpt_addr = 0; logic dbg_ret = 0;
   logic vec_req; logic [19:0] vec_addr; logic [1:0] brk_cause;
   logic dbg_active, run;

   core_launch_dbg #(.LOAD_WORDS(NW)) u_core_launch_dbg (.*);

   always #10 clk = ~clk;

   // behavioural reference: 0 idle, 1 load, 2 jump, 3 enter, 4 handler, 5 run
   int m_st = 0, m_idx = 0, m_cause = 0;
   logic [19:0] m_base = 0, m_tgt = 0, m_bk = 0;
   logic [3:0] m_step = 0; logic m_bken = 0;
   int n_cmp = 0, n_bad = 0; bit started = 0;

   always @(posedge clk) begin
      started = 1;
      if (!rst_n) begin
         m_st = 0; m_idx = 0; m_cause = 0; m_base = 0; m_tgt = 0;
         m_bk = 0; m_step = 0; m_bken = 0;
      end else begin
         case (m_st)
            0: if (launch_req) begin
                  m_step = 0; m_bken = 0; m_bk = 0;
                  if (launch_op[5]) begin m_tgt = launch_pc; m_st = 2; end
                  else begin m_tgt = 0; m_base = launch_addr; m_idx = 0; m_st = 1; end
               end
            1: if (rd_gnt) begin
                  if (m_idx == NW - 1) m_st = 2;
                  m_idx = (m_idx + 1) % NW;
               end
            2: begin m_st = 3; m_cause = 0; end
            3: m_st = 4;
            4: begin
                  if (cfg_we) begin m_step = cfg_step_mask; m_bken = cfg_bkpt_en; m_bk = cfg_bkpt_addr; end
                  if (dbg_ret) m_st = 5;
               end
            5: if (async_req) begin m_st = 3; m_cause = 1; end
               else if (issue_valid && m_bken && issue_pc == m_bk) begin m_st = 3; m_cause = 2; end
               else if (issue_valid && m_step[issue_ctx]) begin m_st = 3; m_cause = 3; end
            default: m_st = 0;
         endcase
      end
   end

   task automatic chk(string req, string nm, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s at %0t: actual=%h expected=%h", req, nm, $time, act, exp);
      end
   endtask

   always @(negedge clk) if (started) begin
      chk("R3", "busy", 32'(busy), 32'(m_st == 1 || m_st == 2));
      chk("R1", "rd_req", 32'(rd_req), 32'(m_st == 1));
      if (m_st == 1) chk("R1", "rd_addr", 32'(rd_addr), 32'(m_base + 20'(m_idx * 4)));
      chk("R1", "rf_we", 32'(rf_we), 32'(m_st == 1 && rd_gnt));
      if (m_st == 1 && rd_gnt) begin
         chk("R1", "rf_waddr", 32'(rf_waddr), 32'(m_idx));
         chk("R1", "rf_wdata", rf_wdata, rd_data);
      end
      chk("R2", "start_pc_valid", 32'(start_pc_valid), 32'(m_st == 2));
      if (m_st == 2) chk("R2", "start_pc", 32'(start_pc), 32'(m_tgt));
      chk("R4", "vec_req", 32'(vec_req), 32'(m_st == 3));
      chk("R5", "vec_addr", 32'(vec_addr), 32'h400 + 32'(core_id) * 4);
      chk("R9", "brk_cause", 32'(brk_cause), 32'(m_cause));
      chk("R10", "dbg_active", 32'(dbg_active), 32'(m_st == 3 || m_st == 4));
      chk("R11", "run", 32'(run), 32'(m_st == 5));
   end

   task automatic tick(int n = 1);
      repeat (n) begin @(negedge clk); #2; end
   endtask

   task automatic do_reset();
      rst_n = 0; tick(2); rst_n = 1; tick();
   endtask

   task automatic handler_ret(logic we, logic [3:0] mask, logic bken, logic [19:0] bk);
      cfg_we = we; cfg_step_mask = mask; cfg_bkpt_en = bken; cfg_bkpt_addr = bk;
      dbg_ret = 1; tick(); cfg_we = 0; dbg_ret = 0;
   endtask

   task automatic issue(logic [19:0] pc, logic [1:0] ctx);
      issue_valid = 1; issue_pc = pc; issue_ctx = ctx; tick(); issue_valid = 0;
   endtask

   initial begin
      do_reset();
      // R5: every core number during idle
      for (int i = 0; i < 16; i++) begin core_id = 4'(i); tick(); end
      // R2, R4, R11: direct launch, handler returns at once, free running
      core_id = 3; launch_op = 8'h20; launch_pc = 20'h2345; launch_addr = 20'h777;
      launch_req = 1; tick(); launch_req = 0;
      tick(3);
      handler_ret(0, 0, 0, 0);
      for (int i = 0; i < 6; i++) issue(20'(i * 4 + 16'h55), 2'(i));
      async_req = 1; tick(); async_req = 0; tick(2);           // R8
      handler_ret(0, 0, 0, 0); tick();

      // R1, R3: copy mode with gaps in the grant, core 15
      do_reset();
      core_id = 15; launch_op = 8'h00; launch_addr = 20'h01000; launch_pc = 20'h3abc;
      launch_req = 1; tick(); launch_req = 0;
      for (int i = 0; i < 24; i++) begin
         rd_gnt = (i % 3) != 1; rd_data = 32'hA500_0000 + 32'(i); tick();
      end
      rd_gnt = 0;
      // R10: async and cfg_we... async ignored inside handler
      async_req = 1; tick(); async_req = 0;
      handler_ret(1, 4'b0100, 0, 0);                            // R6 ctx 2 only
      issue(20'h10, 0); issue(20'h14, 1); issue(20'h18, 2);    // step on ctx2
      tick(2);
      handler_ret(1, 4'b0001, 1, 20'h55);                       // R7 + step main
      issue(20'h55, 0);                                         // R9 bkpt over step
      tick(2);
      handler_ret(0, 0, 0, 0);                                  // settings kept
      async_req = 1; issue_valid = 1; issue_pc = 20'h55; issue_ctx = 0; tick();
      async_req = 0; issue_valid = 0;                           // R9 async wins
      launch_req = 1; launch_op = 8'h20; tick(); launch_req = 0; // R12 ignored
      tick();
      handler_ret(0, 0, 0, 0);
      cfg_we = 1; cfg_step_mask = 0; cfg_bkpt_en = 0; tick(); cfg_we = 0; // R11 ignored
      launch_req = 1; tick(); launch_req = 0;                   // R12 ignored in run
      issue(20'h20, 1);
      issue(20'h24, 0);                                         // still steps
      tick(3);

      // R11: relaunch clears settings
      do_reset();
      core_id = 0; launch_op = 8'h20; launch_pc = 20'h00040; launch_req = 1; tick(); launch_req = 0;
      tick(2);
      handler_ret(0, 0, 0, 0);
      for (int i = 0; i < 8; i++) issue(20'h55, 2'(i));
      tick(2);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(20 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule